// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Macrocell

This block models a single output cell of a sum-of-products programmable logic device. Twelve product terms arrive from the AND array in three groups of four. Each group is ORed into a sum term. Configuration bits decide how the three sum terms are combined and whether the pin shows a registered or a combinational result. The cell holds two flip-flops. Each one has its own clock product term, its own reset product term and its own feedback line back into the array, so the two registers can run on unrelated clocks.

All state is kept in one system clock domain. A clock product term is sampled on every system edge, and a register captures when its term goes from 0 to 1. A small two-state machine per register tracks this. The state names are `CK_LO` and `CK_HI`. Moving from `CK_LO` to `CK_HI` is the capture transition. Moving from `CK_HI` to `CK_LO` is the release transition. Either state holds while the term keeps its level.

A second two-state machine handles security. It starts in `SEC_OPEN`. It moves to `SEC_LOCKED` when the program-security strobe is seen, and the lock acts in that same cycle. It stays in `SEC_LOCKED` until system reset. The lock blocks register preload, hides the second register from observation and forces the verify read-back to all ones. The pin driver is controlled by a per-cell output-enable term. The pin input is passed back into the array on a path of its own, separate from the register feedback.

Top module: `pld_macrocell`

## Requirements
- R1: After `rst_n` is low, `fb1` and `fb2` read 0, the cell is unlocked, and `vfy_cfg` reads `{cfg_comb, cfg_share, cfg_width}`.
- R2: The sum terms are formed as follows: group A is the OR of `pt[3:0]`, group B is the OR of `pt[7:4]` and group C is the OR of `pt[11:8]`.
- R3: In registered mode (`cfg_comb`=0), D1 captures A|B on a 0-to-1 change of `ck1_pt`. When `cfg_share`=1 it captures A|B|C instead. The pin data is `fb1`.
- R4: D2 captures C on a 0-to-1 change of `ck2_pt`, in every mode and independently of `ck1_pt`.
- R5: In combinational mode (`cfg_comb`=1), the pin data depends on `cfg_width`: 0 gives A, 1 gives A|B, and 2 or 3 gives A|B|C. D1 captures B.
- R6: While `rsN_pt` is 1, `fbN` reads 0 in that same cycle and the register is cleared. The reset term wins over preload and over a clock change.
- R7: When the cell is unlocked, `pl_stb`=1 loads `pl_d1` into D1 and `pl_d2` into D2, and it wins over a clock change. When the cell is locked, `pl_stb` has no effect.
- R8: `pin_en` follows `oe_pt`. When `oe_pt`=0 the driver is off and `pin_drv` reads 0.
- R9: `sec_prog`=1 locks the cell in the same cycle, and the lock holds until `rst_n`. While the cell is locked, `vfy_cfg` reads 4'b1111 and `obs_q2` reads 0. While it is unlocked, `obs_q2` equals `fb2`.
- R10: `pin_fb` always equals `pin_in`, whatever the register state and the output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; clock terms are sampled on it |
| rst_n | input | 1 | Active-low system reset |
| pt | input | 12 | Product terms, groups A/B/C at [3:0]/[7:4]/[11:8] |
| ck1_pt | input | 1 | Clock term of D1 |
| ck2_pt | input | 1 | Clock term of D2 |
| rs1_pt | input | 1 | Reset term of D1 |
| rs2_pt | input | 1 | Reset term of D2 |
| oe_pt | input | 1 | Output-enable term |
| cfg_comb | input | 1 | 1 = combinational pin, 0 = registered pin |
| cfg_share | input | 1 | Registered mode: add group C into D1 |
| cfg_width | input | 2 | Combinational pin width select |
| pl_stb | input | 1 | Preload strobe |
| pl_d1 | input | 1 | Preload value for D1 |
| pl_d2 | input | 1 | Preload value for D2 |
| sec_prog | input | 1 | Program the security lock |
| pin_in | input | 1 | Level seen on the pin |
| pin_drv | output | 1 | Pin driver data |
| pin_en | output | 1 | Pin driver enable |
| pin_fb | output | 1 | Pin input path into the array |
| fb1 | output | 1 | D1 feedback into the array |
| fb2 | output | 1 | D2 feedback into the array |
| obs_q2 | output | 1 | Observation of D2 |
| vfy_cfg | output | 4 | Verify read-back of the configuration |

## Verification
The assertions assume that every input holds a steady level from one system edge to the next. They also assume that a clock term counts as rising only when its value sampled now differs from its value sampled one edge earlier, and that the clock terms are low when reset is released. The stimulus meets these assumptions. It changes inputs only on the falling system edge, it changes each clock term by at most one level per cycle, and it holds both clock terms at 0 around every reset. Because of this, every edge of a product-term clock is seen as exactly one capture cycle.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
    typedef enum logic {CK_LO = 1'b0, CK_HI = 1'b1} ck_state_t;
    typedef enum logic {SEC_OPEN = 1'b0, SEC_LOCKED = 1'b1} sec_state_t;
    localparam int N_GRP   = 3;
    localparam int CFG_W   = 4;
    localparam logic [1:0] WID_ONE = 2'd0;
    localparam logic [1:0] WID_TWO = 2'd1;
endpackage

// File: rtl/mc_sum_steer.sv
module mc_sum_steer #(
    parameter int GRP_W = 4
) (
    input  logic [pld_mc_pkg::N_GRP*GRP_W-1:0] pt,
    input  logic                               cfg_comb,
    input  logic                               cfg_share,
    input  logic [1:0]                         cfg_width,
    output logic                               d1,
    output logic                               d2,
    output logic                               comb_o
);
    import pld_mc_pkg::*;

    logic [N_GRP-1:0] sum_t;

    for (genvar g = 0; g < N_GRP; g++) begin : g_sum
        assign sum_t[g] = |pt[g*GRP_W +: GRP_W];
    end

    always_comb begin
        unique case (cfg_width)
            WID_ONE: comb_o = sum_t[0];
            WID_TWO: comb_o = sum_t[0] | sum_t[1];
            default: comb_o = |sum_t;
        endcase
        if (cfg_comb) begin
            d1 = sum_t[1];
        end else begin
            d1 = sum_t[0] | sum_t[1] | (cfg_share & sum_t[2]);
        end
        d2 = sum_t[2];
    end
endmodule

// File: rtl/mc_edge_reg.sv
module mc_edge_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ck_pt,
    input  logic rs_pt,
    input  logic d,
    input  logic pl_en,
    input  logic pl_d,
    output logic q
);
    import pld_mc_pkg::*;

    ck_state_t st_q, st_d;
    logic      q_reg, q_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CK_LO;
            q_reg <= 1'b0;
        end else begin
            st_q  <= st_d;
            q_reg <= q_next;
        end
    end

    always_comb begin
        st_d   = st_q;
        q_next = q_reg;
        unique case (st_q)
            CK_LO: if (ck_pt) begin
                st_d   = CK_HI;
                q_next = d;
            end
            CK_HI: if (!ck_pt) begin
                st_d = CK_LO;
            end
        endcase
        if (rs_pt) begin
            q_next = 1'b0;
        end else if (pl_en) begin
            q_next = pl_d;
        end
    end

    assign q = rs_pt ? 1'b0 : q_reg;
endmodule

// File: rtl/mc_sec_lock.sv
module mc_sec_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_prog,
    output logic locked
);
    import pld_mc_pkg::*;

    sec_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEC_OPEN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEC_OPEN:   if (sec_prog) st_d = SEC_LOCKED;
            SEC_LOCKED: st_d = SEC_LOCKED;
        endcase
        locked = (st_q == SEC_LOCKED) | sec_prog;
    end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
    parameter int GRP_W = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [pld_mc_pkg::N_GRP*GRP_W-1:0]  pt,
    input  logic                                ck1_pt,
    input  logic                                ck2_pt,
    input  logic                                rs1_pt,
    input  logic                                rs2_pt,
    input  logic                                oe_pt,
    input  logic                                cfg_comb,
    input  logic                                cfg_share,
    input  logic [1:0]                          cfg_width,
    input  logic                                pl_stb,
    input  logic                                pl_d1,
    input  logic                                pl_d2,
    input  logic                                sec_prog,
    input  logic                                pin_in,
    output logic                                pin_drv,
    output logic                                pin_en,
    output logic                                pin_fb,
    output logic                                fb1,
    output logic                                fb2,
    output logic                                obs_q2,
    output logic [pld_mc_pkg::CFG_W-1:0]        vfy_cfg
);
    import pld_mc_pkg::*;

    localparam int N_REG = 2;

    logic             d1, d2, comb_o, locked;
    logic [N_REG-1:0] ck_v, rs_v, d_v, pl_v, q_v;

    mc_sum_steer #(.GRP_W(GRP_W)) steer_i (
        .pt(pt), .cfg_comb(cfg_comb), .cfg_share(cfg_share),
        .cfg_width(cfg_width), .d1(d1), .d2(d2), .comb_o(comb_o)
    );

    mc_sec_lock lock_i (
        .clk(clk), .rst_n(rst_n), .sec_prog(sec_prog), .locked(locked)
    );

    assign ck_v = {ck2_pt, ck1_pt};
    assign rs_v = {rs2_pt, rs1_pt};
    assign d_v  = {d2, d1};
    assign pl_v = {pl_d2, pl_d1};

    for (genvar r = 0; r < N_REG; r++) begin : g_reg
        mc_edge_reg reg_i (
            .clk(clk), .rst_n(rst_n), .ck_pt(ck_v[r]), .rs_pt(rs_v[r]),
            .d(d_v[r]), .pl_en(pl_stb & ~locked), .pl_d(pl_v[r]), .q(q_v[r])
        );
    end

    assign fb1     = q_v[0];
    assign fb2     = q_v[1];
    assign pin_en  = oe_pt;
    assign pin_drv = oe_pt & (cfg_comb ? comb_o : q_v[0]);
    assign pin_fb  = pin_in;
    assign obs_q2  = ~locked & q_v[1];
    assign vfy_cfg = locked ? {CFG_W{1'b1}} : {cfg_comb, cfg_share, cfg_width};
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] pt,
    input logic        ck1_pt,
    input logic        ck2_pt,
    input logic        rs1_pt,
    input logic        rs2_pt,
    input logic        cfg_comb,
    input logic        cfg_share,
    input logic        pl_stb,
    input logic        sec_prog,
    input logic        fb1,
    input logic        fb2,
    input logic        obs_q2,
    input logic [3:0]  vfy_cfg
);
    logic ga, gb, gc;
    assign ga = |pt[3:0];
    assign gb = |pt[7:4];
    assign gc = |pt[11:8];

    // R3: registered-mode capture of D1
    a_r3_d1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_comb && ck1_pt && !$past(ck1_pt) && !rs1_pt && !pl_stb)
        |=> (rs1_pt || fb1 == $past(ga | gb | (cfg_share & gc))));

    // R4: D2 capture from group C
    a_r4_d2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ck2_pt && !$past(ck2_pt) && !rs2_pt && !pl_stb)
        |=> (rs2_pt || fb2 == $past(gc)));

    // R6: reset term clears each register
    a_r6_clear1: assert property (@(posedge clk) disable iff (!rst_n)
        rs1_pt |=> !fb1);
    a_r6_clear2: assert property (@(posedge clk) disable iff (!rst_n)
        rs2_pt |=> !fb2);

    // R7: preload has no effect while locked
    a_r7_locked_preload: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_prog && pl_stb && !rs1_pt && !(ck1_pt && !$past(ck1_pt)))
        |=> (rs1_pt || fb1 == $past(fb1)));

    // R9: lock is sticky and hides state
    a_r9_lock_hides: assert property (@(posedge clk) disable iff (!rst_n)
        sec_prog |=> (!obs_q2 && vfy_cfg == 4'b1111));
endmodule

bind pld_macrocell pld_macrocell_chk chk_i (
    .clk(clk), .rst_n(rst_n), .pt(pt), .ck1_pt(ck1_pt), .ck2_pt(ck2_pt),
    .rs1_pt(rs1_pt), .rs2_pt(rs2_pt), .cfg_comb(cfg_comb),
    .cfg_share(cfg_share), .pl_stb(pl_stb), .sec_prog(sec_prog),
    .fb1(fb1), .fb2(fb2), .obs_q2(obs_q2), .vfy_cfg(vfy_cfg)
);

// File: tb/pld_macrocell_tb.sv
module pld_macrocell_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] pt = '0;
    logic ck1_pt = 0, ck2_pt = 0, rs1_pt = 0, rs2_pt = 0, oe_pt = 1;
    logic cfg_comb = 0, cfg_share = 0;
    logic [1:0] cfg_width = 2'd0;
    logic pl_stb = 0, pl_d1 = 0, pl_d2 = 0, sec_prog = 0, pin_in = 0;
    logic pin_drv, pin_en, pin_fb, fb1, fb2, obs_q2;
    logic [3:0] vfy_cfg;

    always #10 clk = ~clk;

    pld_macrocell dut_i (
        .clk(clk), .rst_n(rst_n), .pt(pt), .ck1_pt(ck1_pt), .ck2_pt(ck2_pt),
        .rs1_pt(rs1_pt), .rs2_pt(rs2_pt), .oe_pt(oe_pt), .cfg_comb(cfg_comb),
        .cfg_share(cfg_share), .cfg_width(cfg_width), .pl_stb(pl_stb),
        .pl_d1(pl_d1), .pl_d2(pl_d2), .sec_prog(sec_prog), .pin_in(pin_in),
        .pin_drv(pin_drv), .pin_en(pin_en), .pin_fb(pin_fb), .fb1(fb1),
        .fb2(fb2), .obs_q2(obs_q2), .vfy_cfg(vfy_cfg)
    );

    typedef struct {
        string      tag;
        logic [5:0] bits;
        logic [3:0] vfy;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    logic m_q1 = 0, m_q2 = 0, m_p1 = 0, m_p2 = 0, m_lock = 0;

    task automatic model_reset();
        m_q1 = 0; m_q2 = 0; m_p1 = 0; m_p2 = 0; m_lock = 0;
    endtask

    // driver: model one system edge and push the expected outputs
    task automatic tick(input string tag);
        exp_t e;
        logic a, b, c, d1, d2, cmb, lk, f1, f2;
        a = |pt[3:0]; b = |pt[7:4]; c = |pt[11:8];
        d1 = cfg_comb ? b : (a | b | (cfg_share & c));
        d2 = c;
        cmb = (cfg_width == 2'd0) ? a : (cfg_width == 2'd1) ? (a | b) : (a | b | c);
        lk = m_lock | sec_prog;
        if (rs1_pt) m_q1 = 0;
        else if (pl_stb && !lk) m_q1 = pl_d1;
        else if (ck1_pt && !m_p1) m_q1 = d1;
        if (rs2_pt) m_q2 = 0;
        else if (pl_stb && !lk) m_q2 = pl_d2;
        else if (ck2_pt && !m_p2) m_q2 = d2;
        m_p1 = ck1_pt; m_p2 = ck2_pt; m_lock = lk;
        f1 = rs1_pt ? 1'b0 : m_q1;
        f2 = rs2_pt ? 1'b0 : m_q2;
        e.tag  = tag;
        e.bits = {oe_pt & (cfg_comb ? cmb : f1), oe_pt, pin_in, f1, f2, ~lk & f2};
        e.vfy  = lk ? 4'b1111 : {cfg_comb, cfg_share, cfg_width};
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [5:0] act;
            e = exp_q.pop_front();
            act = {pin_drv, pin_en, pin_fb, fb1, fb2, obs_q2};
            checks++;
            if (act !== e.bits) begin
                errors++;
                $display("FAIL %s outputs {drv,en,fb,fb1,fb2,obs} act %b exp %b", e.tag, act, e.bits);
            end
            checks++;
            if (vfy_cfg !== e.vfy) begin
                errors++;
                $display("FAIL %s vfy_cfg act %b exp %b", e.tag, vfy_cfg, e.vfy);
            end
        end
    end

    task automatic do_reset();
        ck1_pt = 0; ck2_pt = 0; rs1_pt = 0; rs2_pt = 0; pl_stb = 0; sec_prog = 0;
        rst_n = 0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [11:0] lf;
        lf = 12'hACE;
        @(negedge clk);
        do_reset();
        tick("R1");

        // R3: registered mode, walking one, share off then on
        for (int s = 0; s < 2; s++) begin
            cfg_comb = 0; cfg_share = s[0];
            for (int i = 0; i < 12; i++) begin
                pt = 12'h1 << i;
                ck1_pt = 1; tick("R3");
                ck1_pt = 0; tick("R3");
            end
        end

        // R2/R5: combinational mode, every width
        cfg_comb = 1;
        for (int w = 0; w < 4; w++) begin
            cfg_width = w[1:0];
            for (int i = 0; i < 12; i++) begin
                pt = 12'h1 << i;
                ck1_pt = ~ck1_pt;
                tick("R5");
            end
            pt = 12'h000; tick("R2");
        end

        // R4: two clock terms at different rates
        cfg_comb = 0; cfg_share = 0;
        for (int n = 0; n < 60; n++) begin
            lf = {lf[10:0], lf[11] ^ lf[10] ^ lf[9] ^ lf[3]};
            pt = lf;
            if (n % 2 == 0) ck2_pt = ~ck2_pt;
            if (n % 5 == 0) ck1_pt = ~ck1_pt;
            pin_in = lf[0];
            tick("R4");
        end
        ck1_pt = 0; ck2_pt = 0; tick("R4");

        // R6: reset term beats a rising clock and preload
        pt = 12'hFFF; pl_d1 = 1; pl_d2 = 1;
        ck1_pt = 1; ck2_pt = 1; tick("R4");
        ck1_pt = 0; ck2_pt = 0; tick("R6");
        rs1_pt = 1; ck1_pt = 1; pl_stb = 1; tick("R6");
        pl_stb = 0; tick("R6");
        rs1_pt = 0; ck1_pt = 0; tick("R6");
        rs2_pt = 1; ck2_pt = 1; tick("R6");
        rs2_pt = 0; ck2_pt = 0; tick("R6");

        // R7: preload beats a rising clock
        pt = 12'h000; pl_d1 = 1; pl_d2 = 1; pl_stb = 1; ck1_pt = 1; ck2_pt = 1;
        tick("R7");
        pl_stb = 0; ck1_pt = 0; ck2_pt = 0; tick("R7");
        pl_d1 = 0; pl_d2 = 1; pl_stb = 1; tick("R7");
        pl_stb = 0; tick("R7");

        // R8: output enable off, with registered and combinational data high
        pl_d1 = 1; pl_stb = 1; tick("R7");
        pl_stb = 0; oe_pt = 0; tick("R8");
        cfg_comb = 1; pt = 12'hFFF; cfg_width = 2'd2; tick("R8");
        oe_pt = 1; tick("R8");
        cfg_comb = 0; pt = 12'h000;

        // R10: pin input path independent of the rest
        for (int k = 0; k < 4; k++) begin
            pin_in = k[0]; oe_pt = k[1];
            tick("R10");
        end
        oe_pt = 1;

        // R9: lock, then preload ignored and D2 hidden
        pl_d1 = 1; pl_d2 = 1; pl_stb = 1; tick("R7");
        pl_stb = 0; tick("R9");
        sec_prog = 1; pl_d1 = 0; pl_d2 = 0; pl_stb = 1; tick("R9");
        sec_prog = 0; tick("R7");
        pl_stb = 0; tick("R9");
        cfg_share = 1; cfg_width = 2'd1; tick("R9");
        pt = 12'h800; ck2_pt = 1; tick("R9");
        ck2_pt = 0; tick("R9");

        // R1: system reset clears the lock and registers
        do_reset();
        tick("R1");
        tick("R1");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule